// File: doc/BRIEF.md
# Two-Wire Serial Slave Register File with Auto-Increment

This block is a two-wire serial (I2C) slave that lets a host controller read and write a small register space at sub-addresses 0x00 through 0x21. It answers to one fixed 7-bit device address. In a write transfer the first byte after the device address loads an internal pointer. Each data byte that follows goes to the register under the pointer, and the pointer then moves up by one. A read transfer starts at the current pointer and also advances it after every byte sent.

The lower twelve sub-addresses (0x00 to 0x0B) are read-only windows onto status inputs that the surrounding logic drives. The twenty-two upper sub-addresses (0x0C to 0x21) are control registers, and their contents appear on a flat output vector. Sub-address 0x09 is banked. Bit 0 of the control register at 0x0E chooses whether 0x09 shows a status flag byte or the low byte of a monitor value. The pointer stops at an end marker one step past 0x21, so a burst cannot wrap round to the read-only range.

SCL and SDA are sampled by two-flop synchronisers on the system clock. The block drives SDA only as an open-drain pull-down enable. It does not stretch the clock, does not answer a general call and has no 10-bit addressing.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 1101111. For any other address it leaves SDA released on the acknowledge bit and ignores the rest of the transfer until the next start condition.
- R2: In a write transfer the byte after the address is acknowledged and loads the pointer. Each following data byte at a sub-address a in 0x0C..0x21 is acknowledged and stored, it appears on ctrl_o[(a-12)*8 +: 8], and the pointer then advances by one.
- R3: A data byte written while the pointer is in 0x00..0x0B is acknowledged. It changes no register, and the pointer still advances.
- R4: A read transfer returns the byte at the pointer, MSB first, and the pointer advances by one after each byte. Status sub-address a in 0x00..0x0B reads stat_i[a*8 +: 8], and control sub-addresses read back the stored value.
- R5: When the master does not acknowledge a read byte, the block releases SDA and drives no further bits in that transfer.
- R6: Reading sub-address 0x09 gives the flag byte when bit 0 of register 0x0E is 0, and gives mon_lo_i when that bit is 1.
- R7: In the flag byte, bit 0 is an identity bit that always reads 1. Bits 7..1 come from stat_i[79:73].
- R8: Past 0x21 the pointer holds at an end marker. A data byte written at the end marker is not acknowledged and is not stored. A read at the end marker returns 0x00. A sub-address byte above 0x21 sets the pointer to the end marker.
- R9: A start condition at any point begins a new transfer, so a repeated start works. A stop condition at any point ends the transfer, and a partly received byte is discarded.
- R10: After reset all control registers are zero, SDA is released and the pointer is 0x00.
- R11: SDA is sampled on the rising edge of SCL, and the block only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| stat_i | input | 96 | Status bytes for sub-addresses 0x00..0x0B, byte a at bits a*8+7..a*8 |
| mon_lo_i | input | 8 | Monitor low byte, read at 0x09 when banked |
| ctrl_o | output | 176 | Control bytes for 0x0C..0x21, byte a at bits (a-12)*8+7..(a-12)*8 |

## Verification
A wrong pointer can only be seen at the ports on the next data byte. A misplaced write shows on ctrl_o within a few system clocks of the acknowledge bit, and a misplaced read shows on SDA during the next read byte. The reference model therefore tracks its own pointer and its own copy of the control bytes. It compares ctrl_o on every clock outside the short window where a byte is being committed, and checks every acknowledge bit and every read byte when it is received. Bank selection, the identity bit, the end marker and an abandoned byte are each covered by a transfer whose result differs from what a broken design would give.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    localparam int              BYTE_W    = 8;
    localparam int              DEV_W     = 7;
    localparam logic [DEV_W-1:0] DEV_ADDR = 7'b1101111;
    localparam int              RO_COUNT  = 12;
    localparam int              LAST_ADDR = 33;
    localparam int              NCTRL     = LAST_ADDR + 1 - RO_COUNT;
    localparam int              PTR_W     = 6;
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(LAST_ADDR + 1);
    localparam int              FLAG_ADDR = 9;
    localparam int              BANK_REG  = 14;
    localparam int              BANK_BIT  = 0;
    localparam int              ID_BIT    = 0;
    localparam int              CNT_W     = 4;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_ADDR,
        LS_SUB,
        LS_WR,
        LS_RD,
        LS_RACK
    } link_st_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_i};
        s_d.scl_prev = s_q.scl_pipe[STAGES-1];
        s_d.sda_prev = s_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_lvl   = s_q.scl_pipe[STAGES-1];
    assign sda_lvl   = s_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~s_q.scl_prev;
    assign scl_fall  = ~scl_lvl & s_q.scl_prev;
    assign start_det = scl_lvl & s_q.scl_prev & s_q.sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & s_q.scl_prev & ~s_q.sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_link.sv
module i2c_link
    import i2c_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    typedef struct packed {
        link_st_e          state;
        link_st_e          nxt;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              ackslot;
        logic              rack_ok;
        logic [PTR_W-1:0]  ptr;
        logic              oe;
        logic              wr_en;
        logic [PTR_W-1:0]  wr_addr;
        logic [BYTE_W-1:0] wr_data;
    } link_t;

    link_t l_d, l_q;

    always_comb begin
        l_d       = l_q;
        l_d.wr_en = 1'b0;
        if (start_det) begin
            l_d.state   = LS_ADDR;
            l_d.cnt     = '0;
            l_d.ackslot = 1'b0;
            l_d.oe      = 1'b0;
        end else if (stop_det) begin
            l_d.state   = LS_IDLE;
            l_d.ackslot = 1'b0;
            l_d.oe      = 1'b0;
        end else if (l_q.ackslot) begin
            if (scl_fall) begin
                l_d.ackslot = 1'b0;
                l_d.cnt     = '0;
                l_d.state   = l_q.nxt;
                if (l_q.nxt == LS_RD) begin
                    l_d.shreg = rd_data;
                    l_d.oe    = ~rd_data[BYTE_W-1];
                end else begin
                    l_d.oe    = 1'b0;
                end
            end
        end else begin
            unique case (l_q.state)
                LS_ADDR, LS_SUB, LS_WR: begin
                    if (scl_rise && l_q.cnt != CNT_W'(BYTE_W)) begin
                        l_d.shreg = {l_q.shreg[BYTE_W-2:0], sda_lvl};
                        l_d.cnt   = l_q.cnt + 1'b1;
                    end else if (scl_fall && l_q.cnt == CNT_W'(BYTE_W)) begin
                        if (l_q.state == LS_ADDR) begin
                            if (l_q.shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                l_d.ackslot = 1'b1;
                                l_d.oe      = 1'b1;
                                l_d.nxt     = l_q.shreg[0] ? LS_RD : LS_SUB;
                            end else begin
                                l_d.state = LS_IDLE;
                            end
                        end else if (l_q.state == LS_SUB) begin
                            l_d.ackslot = 1'b1;
                            l_d.oe      = 1'b1;
                            l_d.nxt     = LS_WR;
                            l_d.ptr     = (l_q.shreg > BYTE_W'(LAST_ADDR)) ?
                                          PTR_END : l_q.shreg[PTR_W-1:0];
                        end else begin
                            if (l_q.ptr <= PTR_W'(LAST_ADDR)) begin
                                l_d.ackslot = 1'b1;
                                l_d.oe      = 1'b1;
                                l_d.nxt     = LS_WR;
                                l_d.wr_en   = (l_q.ptr >= PTR_W'(RO_COUNT));
                                l_d.wr_addr = l_q.ptr;
                                l_d.wr_data = l_q.shreg;
                                l_d.ptr     = l_q.ptr + 1'b1;
                            end else begin
                                l_d.state = LS_IDLE;
                            end
                        end
                    end
                end
                LS_RD: begin
                    if (scl_fall) begin
                        if (l_q.cnt == CNT_W'(BYTE_W - 1)) begin
                            l_d.oe    = 1'b0;
                            l_d.state = LS_RACK;
                            l_d.ptr   = (l_q.ptr == PTR_END) ? PTR_END : l_q.ptr + 1'b1;
                        end else begin
                            l_d.shreg = {l_q.shreg[BYTE_W-2:0], 1'b0};
                            l_d.cnt   = l_q.cnt + 1'b1;
                            l_d.oe    = ~l_q.shreg[BYTE_W-2];
                        end
                    end
                end
                LS_RACK: begin
                    if (scl_rise) begin
                        l_d.rack_ok = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (l_q.rack_ok) begin
                            l_d.shreg = rd_data;
                            l_d.oe    = ~rd_data[BYTE_W-1];
                            l_d.cnt   = '0;
                            l_d.state = LS_RD;
                        end else begin
                            l_d.state = LS_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q       <= '0;
            l_q.state <= LS_IDLE;
            l_q.nxt   <= LS_IDLE;
        end else begin
            l_q <= l_d;
        end
    end

    assign ptr_o     = l_q.ptr;
    assign sda_oe_o  = l_q.oe;
    assign wr_en_o   = l_q.wr_en;
    assign wr_addr_o = l_q.wr_addr;
    assign wr_data_o = l_q.wr_data;

    // R11
    sda_pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_q.oe) |-> !scl_lvl);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !l_q.oe);

    // R8
    ptr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_q.ptr <= PTR_END);

    // R5
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.state == LS_RACK && scl_fall && !l_q.rack_ok && !start_det && !stop_det)
        |=> !l_q.oe);
endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store
    import i2c_rf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [PTR_W-1:0]           rd_addr,
    input  logic [RO_COUNT*BYTE_W-1:0] stat_i,
    input  logic [BYTE_W-1:0]          mon_lo_i,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NCTRL*BYTE_W-1:0]    ctrl_o
);
    typedef struct packed {
        logic [NCTRL-1:0][BYTE_W-1:0] regs;
    } store_t;

    store_t r_d, r_q;
    logic   bank_sel;

    always_comb begin
        r_d = r_q;
        for (int k = 0; k < NCTRL; k++) begin
            if (wr_en && wr_addr == PTR_W'(k + RO_COUNT)) r_d.regs[k] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bank_sel = r_q.regs[BANK_REG - RO_COUNT][BANK_BIT];

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < RO_COUNT; k++) begin
            if (rd_addr == PTR_W'(k)) rd_data = stat_i[k*BYTE_W +: BYTE_W];
        end
        for (int k = 0; k < NCTRL; k++) begin
            if (rd_addr == PTR_W'(k + RO_COUNT)) rd_data = r_q.regs[k];
        end
        if (rd_addr == PTR_W'(FLAG_ADDR)) begin
            if (bank_sel) begin
                rd_data = mon_lo_i;
            end else begin
                rd_data         = stat_i[FLAG_ADDR*BYTE_W +: BYTE_W];
                rd_data[ID_BIT] = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
        assign ctrl_o[g*BYTE_W +: BYTE_W] = r_q.regs[g];
    end

    // R3
    write_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr >= PTR_W'(RO_COUNT) && wr_addr <= PTR_W'(LAST_ADDR)));
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    input  logic [RO_COUNT*BYTE_W-1:0] stat_i,
    input  logic [BYTE_W-1:0]          mon_lo_i,
    output logic [NCTRL*BYTE_W-1:0]    ctrl_o
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .ptr_o     (ptr),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    i2c_reg_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (ptr),
        .stat_i   (stat_i),
        .mon_lo_i (mon_lo_i),
        .rd_data  (rd_data),
        .ctrl_o   (ctrl_o)
    );
endmodule

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;
    localparam int CLK_P  = 10;
    localparam int QTR    = 8;
    localparam int NRO    = 12;
    localparam int NCT    = 22;
    localparam int ENDP   = 34;
    localparam logic [6:0] DEV = 7'b1101111;
    localparam logic [7:0] MON = 8'hC3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NRO*8-1:0] stat_i;
    logic [NCT*8-1:0] ctrl_o;
    wire  sda_line = sda_m & ~sda_oe;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 1'b0;
    bit prev_oe = 1'b0;
    int mptr = 0;
    logic [7:0] model [NCT];
    logic [7:0] stat_v [NRO];
    logic [7:0] wq [$];

    always #(CLK_P/2) clk = ~clk;

    i2c_regfile_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .stat_i   (stat_i),
        .mon_lo_i (MON),
        .ctrl_o   (ctrl_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        if (a == 9) return model[2][0] ? MON : (stat_v[9] | 8'h01);
        if (a < NRO) return stat_v[a];
        if (a < ENDP) return model[a-NRO];
        return 8'h00;
    endfunction

    // per-clock comparison of control outputs against the model, and R11 monitor
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            for (int k = 0; k < NCT; k++) begin
                if (ctrl_o[k*8 +: 8] !== model[k]) begin
                    chk(1'b0, "R2 ctrl_o byte", ctrl_o[k*8 +: 8], model[k]);
                end
            end
            checks++;
        end
        if (rst_n && sda_oe && !prev_oe) chk(scl_m == 1'b0, "R11 pull while SCL low", scl_m, 0);
        prev_oe = sda_oe;
    end

    task automatic wait_q(input int n);
        repeat (n * QTR) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b1; wait_q(1);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b;    wait_q(1);
        scl_m = 1'b1; wait_q(2);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic recv_bit(output bit b);
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        b = sda_line; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
        sda_m = 1'b1;
    endtask

    task automatic wr_txn(input logic [7:0] sub, input bit do_stop);
        bit a;
        bit ea;
        cmp_en = 1'b0;
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        chk(a, "R1 address ack", a, 1);
        send_byte(sub, a);
        chk(a, "R2 sub-address ack", a, 1);
        mptr = (sub > 8'd33) ? ENDP : int'(sub);
        foreach (wq[k]) begin
            ea = (mptr < ENDP);
            send_byte(wq[k], a);
            if (!ea)             chk(a == ea, "R8 write past end", a, ea);
            else if (mptr < NRO) chk(a == ea, "R3 read-only write ack", a, ea);
            else                 chk(a == ea, "R2 data ack", a, ea);
            if (!ea) break;
            if (mptr >= NRO) model[mptr-NRO] = wq[k];
            mptr++;
        end
        if (do_stop) i2c_stop();
        repeat (6) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic rd_txn(input int n, input string tag);
        bit a;
        logic [7:0] v;
        logic [7:0] e;
        i2c_start();
        send_byte({DEV, 1'b1}, a);
        chk(a, "R1 read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, v);
            e = exp_rd(mptr);
            chk(v == e, tag, v, e);
            if (mptr < ENDP) mptr++;
        end
        repeat (4) @(negedge clk);
        chk(sda_oe == 1'b0, "R5 released after master nack", sda_oe, 0);
        wait_q(1);
        chk(sda_line == 1'b1, "R5 no bits after nack", sda_line, 1);
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit a;
        for (int k = 0; k < NRO; k++) stat_v[k] = 8'(8'h40 + k * 7);
        stat_v[9] = 8'h5A;
        for (int k = 0; k < NRO; k++) stat_i[k*8 +: 8] = stat_v[k];
        for (int k = 0; k < NCT; k++) model[k] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10 reset state
        chk(ctrl_o == '0, "R10 ctrl_o zero after reset", 0, 0);
        chk(sda_oe == 1'b0, "R10 SDA released after reset", sda_oe, 0);
        cmp_en = 1'b1;
        mptr = 0;
        rd_txn(1, "R10 pointer at 0x00 after reset");

        // R1 foreign address: no ack, following byte ignored
        i2c_start();
        send_byte({7'h2A, 1'b0}, a);
        chk(!a, "R1 foreign address nack", a, 0);
        send_byte(8'h0C, a);
        chk(!a, "R1 ignored after foreign address", a, 0);
        i2c_stop();
        repeat (6) @(negedge clk);

        // R2 burst write, R4 read-back
        wq = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        wr_txn(8'h0C, 1'b1);
        wq = {};
        wr_txn(8'h0C, 1'b1);
        rd_txn(5, "R4 control read-back");

        // R3 writes into the read-only range
        wq = {8'hAA, 8'hBB, 8'hCC};
        wr_txn(8'h0A, 1'b1);
        wq = {};
        wr_txn(8'h0A, 1'b1);
        rd_txn(3, "R3 read-only unchanged");

        // R4 status burst
        wr_txn(8'h00, 1'b1);
        rd_txn(4, "R4 status read");

        // R6 R7 banked flag byte
        wr_txn(8'h09, 1'b1);
        rd_txn(1, "R7 flag byte with ID bit");
        wq = {8'h01};
        wr_txn(8'h0E, 1'b1);
        wq = {};
        wr_txn(8'h09, 1'b1);
        rd_txn(2, "R6 banked monitor byte");

        // R8 end of range
        wq = {8'hD1, 8'hD2, 8'hD3, 8'hD4};
        wr_txn(8'h20, 1'b1);
        wq = {};
        wr_txn(8'h21, 1'b1);
        rd_txn(3, "R8 read past end");
        wr_txn(8'h30, 1'b1);
        rd_txn(1, "R8 sub-address above range");
        wq = {8'hE1};
        wr_txn(8'h40, 1'b1);

        // R9 repeated start
        wq = {8'h77};
        wr_txn(8'h15, 1'b1);
        wq = {};
        wr_txn(8'h15, 1'b0);
        rd_txn(1, "R9 repeated start read");

        // R9 stop in the middle of a data byte
        wr_txn(8'h12, 1'b0);
        cmp_en = 1'b0;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        i2c_stop();
        repeat (6) @(negedge clk);
        cmp_en = 1'b1;
        rd_txn(1, "R9 aborted byte not stored");

        repeat (20) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule